// File: doc/BRIEF.md
# Edge-Qualified Event Divider

This block counts transitions of an asynchronous external signal and raises a one-cycle interrupt request once every n+1 counted transitions. The reload value n is a 16-bit word written through a small synchronous register port. Any value from 0x0000 to 0xFFFF is accepted. Reading that same register address returns the live count, not the stored reload value.

An 8-bit mode register controls two things. Its low two bits must hold the event-counting code before any counting takes place. A two-bit polarity field chooses whether falling edges, rising edges or both are counted. A clock-source override input forces rising-edge counting regardless of the polarity field.

The external signal passes through a two-flop synchronizer and then an edge detector. A down counter steps on each qualified edge. When it underflows it reloads itself from the stored reload value.

Top module: `edge_event_divider`

## Requirements
- R1: After reset the count reads 0x0000, the mode register reads 0x0000 and irqPulse is low.
- R2: With busSel=0, busRdata returns the live counter value. With busSel=1, busRdata returns the mode register in bits 7:0 and zero in bits 15:8.
- R3: A write with busSel=0 always stores busWdata as the reload value. It loads the counter only while counting is stopped. While counting, the counter keeps its value until the next underflow reloads it.
- R4: The counter changes on edges only when countEn=1 and mode bits [1:0] equal 01. Any other mode code, or countEn=0, leaves the count unchanged.
- R5: Polarity field mode[3:2]=00 counts falling edges of evtIn only.
- R6: Polarity field mode[3:2]=01 counts rising edges of evtIn only.
- R7: Polarity field mode[3:2]=10 counts both edges of evtIn.
- R8: Polarity field mode[3:2]=11 is reserved, and no edges are counted under it.
- R9: While clkSrcSel=1 the polarity field is treated as 01, so only rising edges are counted, including when the field holds 11.
- R10: On a qualified edge a nonzero count decrements by one. A zero count reloads n and raises irqPulse for exactly one cycle. This gives one pulse per n+1 qualified edges.
- R11: Reload value 0 gives an irqPulse on every qualified edge, with the count held at 0. The value 0xFFFF is stored and read back intact.
- R12: Mode bit 5 always reads 0, whatever is written. Bits 7:6 and bit 4 are stored and read back but do not affect counting.
- R13: An evtIn transition changes the count, and any irqPulse, on the third rising clock edge after it. The count is unchanged after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 1 | Asynchronous external event signal |
| clkSrcSel | input | 1 | Forces rising-edge counting when high |
| countEn | input | 1 | Count start enable |
| busSel | input | 1 | Register select: 0 = counter/reload, 1 = mode |
| busWr | input | 1 | Write strobe, sampled at the clock edge |
| busWdata | input | 16 | Write data (mode uses bits 7:0) |
| busRdata | output | 16 | Combinational read data for the selected register |
| irqPulse | output | 1 | One-cycle underflow interrupt request |

## Verification
Register writes take effect at the first rising clock edge after the write strobe is presented. Reads are combinational, so the bench samples them at the falling edge straight after. A transition on evtIn crosses two synchronizer flops and then the counter register, so its count change and any irqPulse are due after the third rising edge. The bench samples one falling edge earlier to confirm that nothing has moved yet. The pulse-width check samples one cycle after the pulse. Every stimulus is applied at a falling edge, and every check is made at a falling edge a fixed count of cycles later.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

  localparam logic [1:0] OPMODE_EVENT = 2'b01;

  typedef enum logic [1:0] {
    POL_FALL = 2'b00,
    POL_RISE = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } polSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReload;  // store bus word as reload value
    logic loadCount;   // copy bus word straight into the counter
    logic step;        // one qualified edge while counting is active
  } dpStrobe_t;

endpackage

// File: rtl/evtcnt_sync.sv
module evtcnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      evtSync,
  input  logic      countEn,
  input  logic      clkSrcSel,
  input  logic      busSel,
  input  logic      busWr,
  input  logic [7:0] busWdataLo,
  output logic [7:0] modeQ,
  output dpStrobe_t strobe
);
  logic    evtPrev;
  logic    riseDet;
  logic    fallDet;
  logic    qualEdge;
  logic    active;
  polSel_e effPol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPrev <= 1'b0;
      modeQ   <= '0;
    end else begin
      evtPrev <= evtSync;
      if (busWr && busSel)
        modeQ <= busWdataLo & 8'hDF;  // bit 5 is read-only zero
    end
  end

  assign riseDet = evtSync & ~evtPrev;
  assign fallDet = ~evtSync & evtPrev;
  assign effPol  = clkSrcSel ? POL_RISE : polSel_e'(modeQ[3:2]);
  assign active  = countEn && (modeQ[1:0] == OPMODE_EVENT);

  always_comb begin
    unique case (effPol)
      POL_FALL: qualEdge = fallDet;
      POL_RISE: qualEdge = riseDet;
      POL_BOTH: qualEdge = riseDet | fallDet;
      default:  qualEdge = 1'b0;
    endcase
  end

  always_comb begin
    strobe.loadReload = busWr && !busSel;
    strobe.loadCount  = busWr && !busSel && !active;
    strobe.step       = active && qualEdge;
  end
endmodule

// File: rtl/evtcnt_dpath.sv
module evtcnt_dpath
  import evtcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] countQ,
  output logic             irqQ
);
  logic [CNT_W-1:0] reloadQ;
  logic [CNT_W-1:0] reloadNext;
  logic             atZero;

  assign reloadNext = strobe.loadReload ? busWdata : reloadQ;
  assign atZero     = (countQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
      countQ  <= '0;
      irqQ    <= 1'b0;
    end else begin
      reloadQ <= reloadNext;
      irqQ    <= strobe.step && atZero;
      if (strobe.step)
        countQ <= atZero ? reloadNext : countQ - CNT_W'(1);
      else if (strobe.loadCount)
        countQ <= busWdata;
    end
  end
endmodule

// File: rtl/edge_event_divider.sv
module edge_event_divider
  import evtcnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtIn,
  input  logic             clkSrcSel,
  input  logic             countEn,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  output logic             irqPulse
);
  localparam int MODE_W = 8;

  logic             evtSync;
  logic [MODE_W-1:0] modeQ;
  logic [CNT_W-1:0] countVal;
  dpStrobe_t        strobe;

  evtcnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(evtIn), .syncOut(evtSync)
  );

  evtcnt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtSync(evtSync), .countEn(countEn),
    .clkSrcSel(clkSrcSel), .busSel(busSel), .busWr(busWr),
    .busWdataLo(busWdata[MODE_W-1:0]), .modeQ(modeQ), .strobe(strobe)
  );

  evtcnt_dpath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .countQ(countVal), .irqQ(irqPulse)
  );

  assign busRdata = busSel ? CNT_W'(modeQ) : countVal;
endmodule

// File: rtl/evtcnt_checker.sv
module evtcnt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkSrcSel,
  input logic             countEn,
  input logic             busSel,
  input logic             busWr,
  input logic [CNT_W-1:0] busRdata,
  input logic             irqPulse,
  input logic [7:0]       modeQ,
  input logic [CNT_W-1:0] countVal
);
  logic cntWrite;
  assign cntWrite = busWr && !busSel;

  AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> busRdata == countVal);  // R2

  AST_MODE_READ_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    busSel |-> (busRdata[5] == 1'b0 && busRdata[CNT_W-1:8] == '0));  // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((!countEn || modeQ[1:0] != 2'b01) && !cntWrite) |=> $stable(countVal));  // R4

  AST_RESERVED_POL: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[3:2] == 2'b11 && !clkSrcSel && !cntWrite) |=> $stable(countVal));  // R8

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (countVal != '0 && !cntWrite) |=>
      (countVal == $past(countVal) || countVal == $past(countVal) - CNT_W'(1)));  // R10

  AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(countVal) == '0);  // R10
endmodule

bind edge_event_divider evtcnt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .clkSrcSel(clkSrcSel), .countEn(countEn),
  .busSel(busSel), .busWr(busWr), .busRdata(busRdata), .irqPulse(irqPulse),
  .modeQ(modeQ), .countVal(countVal)
);

// File: tb/edge_event_divider_tb.sv
module edge_event_divider_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtIn = 1'b0;
  logic        clkSrcSel = 1'b0;
  logic        countEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqPulse;

  int errCnt = 0;
  int chkCnt = 0;
  int irqSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_event_divider dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .clkSrcSel(clkSrcSel),
    .countEn(countEn), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqPulse(irqPulse)
  );

  always @(negedge clk) if (rstN && irqPulse) irqSeen++;

  // {pol[1:0], clkSrcSel, startLevel, expected count after one toggle from 5}
  localparam logic [7:0] VEC [11] = '{
    {2'b00, 1'b0, 1'b1, 4'd4},  // R5 falling counted
    {2'b00, 1'b0, 1'b0, 4'd5},  // R5 rising ignored
    {2'b01, 1'b0, 1'b0, 4'd4},  // R6 rising counted
    {2'b01, 1'b0, 1'b1, 4'd5},  // R6 falling ignored
    {2'b10, 1'b0, 1'b0, 4'd4},  // R7 rising counted
    {2'b10, 1'b0, 1'b1, 4'd4},  // R7 falling counted
    {2'b11, 1'b0, 1'b0, 4'd5},  // R8 rising ignored
    {2'b11, 1'b0, 1'b1, 4'd5},  // R8 falling ignored
    {2'b00, 1'b1, 1'b0, 4'd4},  // R9 forced rising counted
    {2'b00, 1'b1, 1'b1, 4'd5},  // R9 falling ignored
    {2'b11, 1'b1, 1'b0, 4'd4}   // R9 overrides reserved code
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic sel, input logic [15:0] data);
    busSel = sel; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [15:0] val);
    busSel = sel;
    #1;
    val = busRdata;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkCount(input string req, input logic [15:0] exp);
    logic [15:0] v;
    readReg(1'b0, v);
    check(req, v, exp);
  endtask

  task automatic pulse();
    evtIn = 1'b1; tick(4);
    evtIn = 1'b0; tick(4);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] model;
    logic [15:0] prev;
    logic        expIrq;
    int          base;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    checkCount("R1 count", 16'h0000);
    readReg(1'b1, v); check("R1 mode", v, 16'h0000);
    check("R1 irq", {15'b0, irqPulse}, 16'h0000);

    // polarity table (R5..R9), with R2 live read
    foreach (VEC[i]) begin
      countEn = 1'b0;
      regWrite(1'b1, {12'b0, VEC[i][7:6], 2'b01});
      clkSrcSel = VEC[i][5];
      evtIn = VEC[i][4];
      tick(4);
      regWrite(1'b0, 16'd5);
      countEn = 1'b1;
      tick(1);
      evtIn = ~VEC[i][4];
      tick(3);
      checkCount($sformatf("R2/R5-R9 vec%0d", i), {12'b0, VEC[i][3:0]});
      tick(2);
    end
    countEn = 1'b0; clkSrcSel = 1'b0; evtIn = 1'b0; tick(4);

    // R10/R13 divide by n+1 with latency
    regWrite(1'b1, 16'h0005);
    regWrite(1'b0, 16'd2);
    countEn = 1'b1;
    base = irqSeen;
    model = 16'd2;
    for (int k = 0; k < 6; k++) begin
      prev = model;
      expIrq = (model == 0);
      model = (model == 0) ? 16'd2 : model - 16'd1;
      evtIn = 1'b1; tick(2);
      checkCount("R13 no change after two clocks", prev);
      tick(1);
      checkCount("R10 count after edge", model);
      check("R10 irq at edge", {15'b0, irqPulse}, {15'b0, expIrq});
      tick(1);
      if (expIrq) check("R10 irq width", {15'b0, irqPulse}, 16'h0000);
      evtIn = 1'b0; tick(3);
    end
    check("R10 irq total", 16'(irqSeen - base), 16'd2);

    // R3 write while counting: count kept, reload used at underflow
    countEn = 1'b0;
    regWrite(1'b0, 16'd3);
    countEn = 1'b1;
    regWrite(1'b0, 16'd7);
    checkCount("R3 write while counting keeps count", 16'd3);
    repeat (4) pulse();
    checkCount("R3 underflow reloads new value", 16'd7);

    // R4 gating by mode code and enable
    countEn = 1'b0;
    regWrite(1'b1, 16'h0004);
    regWrite(1'b0, 16'd4);
    countEn = 1'b1;
    pulse();
    checkCount("R4 mode 00 no count", 16'd4);
    regWrite(1'b1, 16'h0006);
    pulse();
    checkCount("R4 mode 10 no count", 16'd4);
    regWrite(1'b1, 16'h0005);
    countEn = 1'b0;
    pulse();
    checkCount("R4 countEn low no count", 16'd4);

    // R11 reload zero and full-scale value
    regWrite(1'b0, 16'd0);
    countEn = 1'b1;
    base = irqSeen;
    repeat (3) pulse();
    check("R11 irq every edge", 16'(irqSeen - base), 16'd3);
    checkCount("R11 count stays zero", 16'd0);
    countEn = 1'b0;
    regWrite(1'b0, 16'hFFFF);
    checkCount("R11 full-scale readback", 16'hFFFF);

    // R12 mode bits
    regWrite(1'b1, 16'h00FF);
    readReg(1'b1, v); check("R12 bit5 reads zero", v, 16'h00DF);
    regWrite(1'b1, 16'h00D5);
    readReg(1'b1, v); check("R12 spare bits readback", v, 16'h00D5);
    regWrite(1'b0, 16'd9);
    countEn = 1'b1;
    pulse();
    checkCount("R12 spare bits no effect", 16'd8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chkCnt++;
      errCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule